// File: doc/BRIEF.md
# Compare/Capture Timer

This block is a timer peripheral of the kind found next to a small processor core. A 16-bit counter runs freely and advances once per tick of a prescaler, whose ratio is a power of two chosen by software. Five compare channels each hold a 16-bit target value. A channel raises its event flag in the same clock cycle that the counter takes that value, and this includes the step from 0xFFFF to 0x0000. Three capture channels watch external pins through synchronizers. On a rising edge, a capture channel stores the counter value and raises its flag.

Software reaches every register over a byte-wide register bus. The bus has a select strobe, a write strobe, a 5-bit address, write data and combinational read data. Each 16-bit quantity appears as two bytes, with the high byte at the even address. One interrupt line reports whether any flag is set whose enable bit is also set. The bus is a plain register port, so it has no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data follows `bus_addr` in the same cycle. The capture pins and `irq` are plain level signals.

Address map: 0x00/0x01 counter high/low (read only), 0x02..0x07 capture 1..3 high/low (read only), 0x08..0x11 compare 1..5 high/low, 0x12 enable register, 0x13 event register, 0x14 control register (bits [1:0] select the prescale ratio). Addresses that are not listed read as zero.

Top module: `cc_timer`

## Requirements
- R1: The counter at 0x00/0x01 advances by exactly one per prescaler tick and wraps from 0xFFFF to 0x0000; it never moves by any other amount.
- R2: Control bits [1:0] select the ratio of clock cycles per counter step: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 16.
- R3: Compare channel n (1..5) sets event bit 8-n (bit 7 for channel 1 down to bit 3 for channel 5) on the clock edge where the counter takes the channel's compare value. The bit is therefore visible in the same cycle the counter reads that value and clear one counter value earlier. This also holds when the target is 0x0000, reached by wrapping.
- R4: A compare event bit is set whether or not its own enable bit is set, as long as at least one of enable bits [7:3] is set. While enable bits [7:3] are all clear, no compare event bit is ever set.
- R5: Capture channel k (1..3) latches the counter on a rising edge of `cap_in[k-1]` and sets event bit 3-k (bit 2 for channel 1 down to bit 0 for channel 3). The pin passes through two synchronizer stages, so at ratio 1 the stored value equals the counter value read while the pin first goes high, plus 2. The event bit appears three edges after the pin rises. A falling edge sets nothing.
- R6: Writing the event register clears every bit written as 1 and leaves every bit written as 0 unchanged. A new event in the same cycle wins over a clear.
- R7: `irq` is high exactly when some event bit and the matching enable bit are both 1. It reflects a write to the enable or event register in the cycle right after the write edge.
- R8: Reset clears the counter, the prescaler, control, enable, event, compare and capture registers, and drives `irq` low.
- R9: Compare registers read back the bytes written to them at their high and low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cap_in | input | 3 | Capture pins, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a compare match on the wrap from 0xFFFF to 0x0000. The counter has no load path, so the stimulus sets ratio 1 and targets 0x0000, then lets the counter run through a whole period. Randomized trials pick a channel, a prescale ratio, an enable pattern and a target a short distance ahead of the counter value read back. The bench then steps the bus one cycle at a time until the counter shows the target, and checks that the event bit rose in exactly that cycle. Some trials use enable patterns with only capture bits set, which exercises the case where compare detection is inactive.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam int A_CNT_HI = 'h00;
  localparam int A_CAP_B  = 'h02;
  localparam int A_CMP_B  = 'h08;
  localparam int A_ENABLE = 'h12;
  localparam int A_EVENT  = 'h13;
  localparam int A_CTRL   = 'h14;

  // True when cmp was stepped over while the counter moved from prev to cur,
  // prev excluded, cur included, with wrap handled.
  function automatic logic window_hit(cnt_t prev, cnt_t cur, cnt_t cmp);
    if (prev < cur)      return (cmp > prev) && (cmp <= cur);
    else if (prev > cur) return (cmp > prev) || (cmp <= cur);
    else                 return 1'b0;
  endfunction

  // Cycles per step minus one, for each select code.
  function automatic logic [3:0] ratio_m1(logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd0;
      2'b01:   return 4'd3;
      2'b10:   return 4'd7;
      default: return 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/cct_timebase.sv
module cct_timebase
  import cct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] psel,
  output logic       tick,
  output cnt_t       count,
  output cnt_t       count_next
);
  logic [3:0] pre_q;
  cnt_t       cnt_q;

  assign tick       = (pre_q >= ratio_m1(psel));
  assign count      = cnt_q;
  assign count_next = cnt_q + cnt_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? 4'd0 : pre_q + 4'd1;
      if (tick) cnt_q <= count_next;
    end
  end
endmodule

// File: rtl/cct_compare_bank.sv
module cct_compare_bank
  import cct_pkg::*;
#(
  parameter int N_CH = 5,
  parameter int BASE = A_CMP_B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                active,
  input  logic                tick,
  input  cnt_t                count,
  input  cnt_t                count_next,
  output logic [N_CH*CNT_W-1:0] cmp_flat,
  output logic [N_CH-1:0]     hit
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int A_HI = BASE + 2*i;
    cnt_t cmp_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(A_HI))     cmp_q[CNT_W-1:BYTE_W] <= wr_data;
        if (wr_addr == ADDR_W'(A_HI + 1)) cmp_q[BYTE_W-1:0]     <= wr_data;
      end
    end

    assign cmp_flat[i*CNT_W +: CNT_W] = cmp_q;
    assign hit[i] = active && tick && window_hit(count, count_next, cmp_q);
  end
endmodule

// File: rtl/cct_capture_bank.sv
module cct_capture_bank
  import cct_pkg::*;
#(
  parameter int N_CH  = 3,
  parameter int SYNC_N = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        pins,
  input  cnt_t                   count,
  output logic [N_CH*CNT_W-1:0]  cap_flat,
  output logic [N_CH-1:0]        evt
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [SYNC_N-1:0] sync_q;
    logic              last_q;
    cnt_t              cap_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q <= '0;
        last_q <= 1'b0;
        cap_q  <= '0;
      end else begin
        sync_q <= {sync_q[SYNC_N-2:0], pins[k]};
        last_q <= sync_q[SYNC_N-1];
        if (evt[k]) cap_q <= count;
      end
    end

    assign evt[k] = sync_q[SYNC_N-1] & ~last_q;
    assign cap_flat[k*CNT_W +: CNT_W] = cap_q;
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int N_CMP  = 5,
  parameter int N_CAP  = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [N_CAP-1:0]  cap_in,
  output logic              irq
);
  localparam int EV_W = N_CMP + N_CAP;

  logic              wr_en;
  logic              tick;
  cnt_t              count_q, count_nx;
  logic [1:0]        ctrl_q;
  logic [EV_W-1:0]   mask_q, flag_q, set_v, clr_v;
  logic [N_CMP-1:0]  cmp_hit;
  logic [N_CAP-1:0]  cap_evt;
  logic [N_CMP*CNT_W-1:0] cmp_flat;
  logic [N_CAP*CNT_W-1:0] cap_flat;
  logic              cmp_active;

  assign wr_en      = bus_sel & bus_wr;
  assign cmp_active = |mask_q[EV_W-1 -: N_CMP];

  cct_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .psel(ctrl_q), .tick(tick),
    .count(count_q), .count_next(count_nx)
  );

  cct_compare_bank #(.N_CH(N_CMP), .BASE(A_CMP_B)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .active(cmp_active), .tick(tick),
    .count(count_q), .count_next(count_nx), .cmp_flat(cmp_flat), .hit(cmp_hit)
  );

  cct_capture_bank #(.N_CH(N_CAP), .SYNC_N(SYNC_N)) u_cap (
    .clk(clk), .rst_n(rst_n), .pins(cap_in), .count(count_q),
    .cap_flat(cap_flat), .evt(cap_evt)
  );

  // Event sources into the fixed bit map: compares from the top bit down,
  // captures from bit N_CAP-1 down.
  always_comb begin
    set_v = '0;
    for (int i = 0; i < N_CMP; i++) set_v[EV_W-1-i] = cmp_hit[i];
    for (int k = 0; k < N_CAP; k++) set_v[N_CAP-1-k] = cap_evt[k];
    clr_v = (wr_en && bus_addr == ADDR_W'(A_EVENT)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && bus_addr == ADDR_W'(A_CTRL))   ctrl_q <= bus_wdata[1:0];
      if (wr_en && bus_addr == ADDR_W'(A_ENABLE)) mask_q <= bus_wdata;
      flag_q <= (flag_q & ~clr_v) | set_v;
    end
  end

  assign irq = |(flag_q & mask_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CNT_HI))     bus_rdata = count_q[CNT_W-1:BYTE_W];
    if (bus_addr == ADDR_W'(A_CNT_HI + 1)) bus_rdata = count_q[BYTE_W-1:0];
    for (int k = 0; k < N_CAP; k++) begin
      if (bus_addr == ADDR_W'(A_CAP_B + 2*k))     bus_rdata = cap_flat[k*CNT_W+BYTE_W +: BYTE_W];
      if (bus_addr == ADDR_W'(A_CAP_B + 2*k + 1)) bus_rdata = cap_flat[k*CNT_W +: BYTE_W];
    end
    for (int i = 0; i < N_CMP; i++) begin
      if (bus_addr == ADDR_W'(A_CMP_B + 2*i))     bus_rdata = cmp_flat[i*CNT_W+BYTE_W +: BYTE_W];
      if (bus_addr == ADDR_W'(A_CMP_B + 2*i + 1)) bus_rdata = cmp_flat[i*CNT_W +: BYTE_W];
    end
    if (bus_addr == ADDR_W'(A_ENABLE)) bus_rdata = mask_q;
    if (bus_addr == ADDR_W'(A_EVENT))  bus_rdata = flag_q;
    if (bus_addr == ADDR_W'(A_CTRL))   bus_rdata = {6'd0, ctrl_q};
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cct_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input cnt_t              count,
  input logic [7:0]        mask,
  input logic [7:0]        flags,
  input logic [1:0]        psel
);
  // R1: counter holds or steps by one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> count == $past(count) + cnt_t'(1));

  // R2: at ratio 1 the counter steps on every edge
  p_ratio_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == 2'b00 && $past(psel) == 2'b00 && $past(rst_n)) |-> count == $past(count) + cnt_t'(1));

  // R4: no compare bit rises while compare enables are all clear
  p_cmp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask[7:3]) == 5'd0) |-> ((flags[7:3] & ~$past(flags[7:3])) == 5'd0));

  // R6: event bits only fall after a write to the event register
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags) != 8'd0) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(A_EVENT)));

  // R7: no enables means no interrupt
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'd0) |-> !irq);
endmodule

bind cc_timer cc_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .irq(irq), .count(count_q), .mask(mask_q),
  .flags(flag_q), .psel(ctrl_q)
);

// File: tb/test_cc_timer.sv
module test_cc_timer;
  localparam logic [4:0] T_CNT_HI = 5'h00, T_CNT_LO = 5'h01, T_CAP = 5'h02,
                         T_CMP = 5'h08, T_EN = 5'h12, T_EV = 5'h13, T_CTL = 5'h14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] cap_in = '0;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cc_timer i_cc_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .irq(irq)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd16(logic [4:0] a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(a, h); rd(a + 5'd1, l);
    v = {h, l};
  endtask

  function automatic int ratio_of(int sel);
    case (sel) 0: return 1; 1: return 4; 2: return 8; default: return 16; endcase
  endfunction

  function automatic logic [7:0] cmp_bit(int ch);
    return 8'h80 >> ch;
  endfunction

  // Compare channel ch (0-based) aimed at tgt; step until the counter shows tgt.
  task automatic cmp_trial(int ch, int psel, logic [7:0] m, logic [15:0] tgt, int lim);
    logic [15:0] c;
    logic [7:0]  f, pf;
    int          n;
    wr(T_CTL, 8'(psel));
    wr(T_EN, m);
    wr(T_CMP + 5'(2*ch), tgt[15:8]);
    wr(T_CMP + 5'(2*ch + 1), tgt[7:0]);
    wr(T_EV, 8'hFF);
    rd(T_EV, pf);
    n = 0;
    forever begin
      @(negedge clk);
      rd16(T_CNT_HI, c); rd(T_EV, f);
      if (c == tgt || n > lim) break;
      pf = f; n++;
    end
    check("R3 target reached", int'(c), int'(tgt));
    check("R3/R4 event at match", int'((f & cmp_bit(ch)) != 0), int'(m[7:3] != 0));
    check("R3 event clear before match", int'((pf & cmp_bit(ch)) != 0), 0);
    check("R7 irq level", int'(irq), int'((f & m) != 0));
  endtask

  initial begin
    logic [15:0] c0, c1, v;
    logic [7:0]  d;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    rd(T_EN, d);  check("R8 enable reset", d, 0);
    rd(T_EV, d);  check("R8 event reset", d, 0);
    rd(T_CTL, d); check("R8 ctrl reset", d, 0);
    rd16(T_CMP + 5'd8, v); check("R8 compare5 reset", v, 0);
    rd16(T_CAP, v); check("R8 capture1 reset", v, 0);
    check("R8 irq reset", irq, 0);
    rd16(T_CNT_HI, v); check("R8 counter near zero", int'(v < 16'd4), 1);

    // R9: compare readback
    wr(T_CMP + 5'd2, 8'hA5); wr(T_CMP + 5'd3, 8'h3C);
    rd16(T_CMP + 5'd2, v); check("R9 compare2 readback", v, 16'hA53C);

    // R1/R2: step counts over whole prescale periods
    for (int s = 0; s < 4; s++) begin
      wr(T_CTL, 8'(s));
      repeat (20) @(negedge clk);
      rd16(T_CNT_HI, c0);
      repeat (10 * ratio_of(s)) @(negedge clk);
      rd16(T_CNT_HI, c1);
      check("R2 steps per window", int'(c1 - c0), 10);
    end

    // R3/R4: random compare trials
    for (int t = 0; t < 12; t++) begin
      int ch, ps, off;
      logic [7:0] m;
      ch = $urandom_range(0, 4);
      ps = $urandom_range(0, 3);
      off = $urandom_range(12, 40);
      m = 8'($urandom());
      if (t % 4 == 3) m = m & 8'h07;
      else if (t % 4 == 1) m = (m & 8'h07) | (cmp_bit((ch + 1) % 5));
      wr(T_CTL, 8'(ps));
      rd16(T_CNT_HI, c0);
      cmp_trial(ch, ps, m, c0 + 16'(off), 2000);
    end

    // R4: inactive compares, event never set
    wr(T_CTL, 8'd0); wr(T_EN, 8'h00);
    rd16(T_CNT_HI, c0);
    wr(T_CMP, 8'(((c0 + 16'd8) >> 8))); wr(T_CMP + 5'd1, 8'(c0 + 16'd8));
    wr(T_EV, 8'hFF);
    repeat (40) @(negedge clk);
    rd(T_EV, d); check("R4 idle no compare events", d & 8'hF8, 0);

    // R5: capture latching and flags at ratio 1
    for (int t = 0; t < 6; t++) begin
      int k;
      k = $urandom_range(0, 2);
      wr(T_EV, 8'hFF);
      @(negedge clk);
      rd16(T_CNT_HI, c0);
      cap_in[k] = 1'b1;
      repeat (3) @(negedge clk);
      rd16(T_CAP + 5'(2*k), v);
      check("R5 captured value", v, int'(c0 + 16'd2));
      rd(T_EV, d); check("R5 capture event bit", int'(d[2-k]), 1);
      cap_in[k] = 1'b0;
      repeat (2) @(negedge clk);
      wr(T_EV, 8'h07);
      repeat (6) @(negedge clk);
      rd(T_EV, d); check("R5 falling edge no event", d & 8'h07, 0);
    end

    // R6/R7: clear semantics and interrupt tracking
    cap_in = 3'b111;
    repeat (4) @(negedge clk);
    rd(T_EV, d); check("R5 all capture bits", d & 8'h07, 7);
    wr(T_EV, 8'h00); rd(T_EV, d); check("R6 zero write keeps", d & 8'h07, 7);
    wr(T_EV, 8'h02); rd(T_EV, d); check("R6 one write clears", d & 8'h07, 5);
    wr(T_EN, 8'h04); check("R7 irq on enable write", irq, 1);
    wr(T_EN, 8'h02); check("R7 irq off for cleared bit", irq, 0);
    wr(T_EN, 8'h04); wr(T_EV, 8'h04); check("R7 irq off after clear", irq, 0);
    cap_in = 3'b000;

    // R3: match on wrap to zero
    cmp_trial(4, 0, 8'h08, 16'h0000, 70000);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule